// File: doc/BRIEF.md
# Guarded Delayed-Branch Controller

This block holds the fetch program counter of a five-slot VLIW core that has no branch prediction. Fetch runs sequentially, one address per unstalled cycle. An issuing instruction can carry up to three guarded branch operations. Each operation names a guard bit, a sense (jump when the guard is set, or jump when it is clear) and a target address. When at least one branch is taken, the controller lets three more instructions issue as delay slots. On the edge where the third of them issues, it loads the target into the fetch PC.

Interrupts are accepted only at these redirect points. A pending request does nothing until a taken-branch redirect happens. At that redirect, fetch goes to the interrupt vector instead of the branch target, and the branch target is kept as the return address. A stall freezes the PC and the countdown. The redirect in progress is kept. A new instruction with branches can be accepted on every cycle.

Top module: `brctl_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `fetch_pc` equals `RESET_PC` and `redirect`, `irq_ack` and `irq_ret` are 0.
- R2: On any cycle with `stall` low and no redirect, `fetch_pc` advances by 1 on the next edge.
- R3: If a taken branch issues with no redirect pending, `fetch_pc` takes its target on the edge where the third later issued instruction issues. Every edge before that is sequential.
- R4: A branch in slot s is taken when `br_valid[s]` is 1 and `br_guard[s]` equals `br_sense[s]`. Sense 1 means jump-if-true and sense 0 means jump-if-false.
- R5: When several branches in one instruction are taken, the target of the lowest-numbered slot is used.
- R6: While a redirect is pending, branches in the issuing instructions are ignored, including the one that triggers the redirect, and the countdown is not restarted.
- R7: When `stall` is high, no instruction issues. `fetch_pc` and the countdown hold, and the pending redirect still happens after the remaining delay slots issue.
- R8: Cycles with `instr_valid` low do not count as delay slots, and their branch descriptors are ignored.
- R9: `irq_req` has no effect except at a redirect edge. At that edge, with `irq_req` high, `fetch_pc` becomes `irq_vec`, `irq_ret` becomes the branch target, and `irq_ack` is high for exactly the following cycle.
- R10: `redirect` is high for exactly one cycle after each edge on which the fetch PC was loaded from a branch target or a vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is presented for issue |
| stall | input | 1 | Freeze issue, PC and countdown |
| br_valid | input | NBR | Branch operation present, per slot |
| br_sense | input | NBR | 1 = jump if guard true, 0 = jump if guard false |
| br_guard | input | NBR | Guard register value, per slot |
| br_target | input | NBR x 32 | Target address, per slot |
| irq_req | input | 1 | Interrupt pending |
| irq_vec | input | 32 | Interrupt vector address |
| fetch_pc | output | 32 | Next fetch address |
| redirect | output | 1 | Pulse after a non-sequential PC load |
| irq_ack | output | 1 | Pulse after an interrupt was accepted |
| irq_ret | output | 32 | Return address saved at interrupt entry |

## Verification
The embedded properties check several behaviours on every cycle. They cover the stall hold of the PC and of the countdown, the sequential step, and loading the saved target or the vector at the redirect edge. They also check the one-step decrement of a running countdown, its legal range, and that slot 0 wins when it is taken. Only the bench's scenarios can show the end-to-end counts. These include three issued delay slots between a branch and the PC change, and holes from stalls or invalid cycles that do not consume slots. They also include branches inside a pending window that are ignored, and an interrupt that stays pending until a later branch.

// File: rtl/brctl_pkg.sv
package brctl_pkg;

    localparam int unsigned PC_W = 32;

    typedef logic [PC_W-1:0] pc_t;

    // result of the per-instruction slot arbitration
    typedef struct packed {
        logic hit;
        pc_t  target;
    } br_pick_t;

    // jump-if-true (sense=1) or jump-if-false (sense=0)
    function automatic logic br_cond_met(input logic sense, input logic guard);
        return sense == guard;
    endfunction

    function automatic pc_t pc_step(input pc_t pc);
        return pc + pc_t'(1);
    endfunction

endpackage

// File: rtl/brctl_select.sv
module brctl_select
    import brctl_pkg::*;
#(
    parameter int unsigned NBR = 3
) (
    input  logic [NBR-1:0]           vld,
    input  logic [NBR-1:0]           sense,
    input  logic [NBR-1:0]           guard,
    input  logic [NBR-1:0][PC_W-1:0] target,
    output br_pick_t                 pick
);

    logic [NBR-1:0] taken;

    generate
        for (genvar s = 0; s < NBR; s++) begin : g_cond
            assign taken[s] = vld[s] & br_cond_met(sense[s], guard[s]);
        end
    endgenerate

    // scan from the top slot down so the lowest taken slot is written last
    always_comb begin
        pick = '0;
        for (int s = NBR - 1; s >= 0; s--) begin
            if (taken[s]) begin
                pick.hit    = 1'b1;
                pick.target = target[s];
            end
        end
    end

endmodule

// File: rtl/brctl_delay.sv
module brctl_delay
    import brctl_pkg::*;
#(
    parameter int unsigned DELAY = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     issue,
    input  br_pick_t pick,
    output logic     fire,
    output logic     busy,
    output pc_t      tgt
);

    localparam int unsigned CNT_W = $clog2(DELAY + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    pc_t              tgt_q;

    assign fire = busy_q & issue & (cnt_q == CNT_W'(1));
    assign busy = busy_q;
    assign tgt  = tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            tgt_q  <= '0;
        end else if (issue) begin
            if (busy_q) begin
                // branches inside the window are dropped
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end else if (pick.hit) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(DELAY);
                tgt_q  <= pick.target;
            end
        end
    end

    p_cnt_range_r6: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q != '0) && (cnt_q <= CNT_W'(DELAY)));

    p_count_down_r6: assert property (@(posedge clk) disable iff (rst)
        busy_q && issue && (cnt_q > CNT_W'(1)) |=>
            busy_q && (cnt_q == $past(cnt_q) - CNT_W'(1)) && $stable(tgt_q));

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        busy_q && !issue |=> busy_q && $stable(cnt_q) && $stable(tgt_q));

endmodule

// File: rtl/brctl_pc.sv
module brctl_pc
    import brctl_pkg::*;
#(
    parameter pc_t RESET_PC = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic stall,
    input  logic fire,
    input  pc_t  tgt,
    input  logic irq_req,
    input  pc_t  irq_vec,
    output pc_t  pc,
    output logic redirect,
    output logic irq_ack,
    output pc_t  irq_ret
);

    pc_t  pc_q, ret_q;
    logic redir_q, ack_q;
    logic take_irq;

    assign take_irq = fire & irq_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= RESET_PC;
            ret_q   <= '0;
            redir_q <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            redir_q <= fire;
            ack_q   <= take_irq;
            if (take_irq) begin
                ret_q <= tgt;
            end
            if (!stall) begin
                if (take_irq)  pc_q <= irq_vec;
                else if (fire) pc_q <= tgt;
                else           pc_q <= pc_step(pc_q);
            end
        end
    end

    assign pc       = pc_q;
    assign redirect = redir_q;
    assign irq_ack  = ack_q;
    assign irq_ret  = ret_q;

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(pc_q));

    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        !stall && !fire |=> pc_q == pc_t'($past(pc_q) + pc_t'(1)));

    p_branch_load_r3: assert property (@(posedge clk) disable iff (rst)
        fire && !irq_req |=> pc_q == $past(tgt) && redir_q && !ack_q);

    p_irq_entry_r9: assert property (@(posedge clk) disable iff (rst)
        fire && irq_req |=> pc_q == $past(irq_vec) && ack_q && ret_q == $past(tgt));

    p_no_stray_ack_r9: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !ack_q && !redir_q);

endmodule

// File: rtl/brctl_unit.sv
module brctl_unit
    import brctl_pkg::*;
#(
    parameter int unsigned NBR      = 3,
    parameter int unsigned DELAY    = 3,
    parameter pc_t         RESET_PC = 32'h0000_1000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     instr_valid,
    input  logic                     stall,
    input  logic [NBR-1:0]           br_valid,
    input  logic [NBR-1:0]           br_sense,
    input  logic [NBR-1:0]           br_guard,
    input  logic [NBR-1:0][PC_W-1:0] br_target,
    input  logic                     irq_req,
    input  logic [PC_W-1:0]          irq_vec,
    output logic [PC_W-1:0]          fetch_pc,
    output logic                     redirect,
    output logic                     irq_ack,
    output logic [PC_W-1:0]          irq_ret
);

    logic     issue;
    br_pick_t pick;
    logic     fire, busy;
    pc_t      tgt;

    // an instruction issues only when present and not frozen
    assign issue = instr_valid & ~stall;

    brctl_select #(.NBR(NBR)) u_select (
        .vld    (br_valid),
        .sense  (br_sense),
        .guard  (br_guard),
        .target (br_target),
        .pick   (pick)
    );

    brctl_delay #(.DELAY(DELAY)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .issue (issue),
        .pick  (pick),
        .fire  (fire),
        .busy  (busy),
        .tgt   (tgt)
    );

    brctl_pc #(.RESET_PC(RESET_PC)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .stall    (stall),
        .fire     (fire),
        .tgt      (tgt),
        .irq_req  (irq_req),
        .irq_vec  (irq_vec),
        .pc       (fetch_pc),
        .redirect (redirect),
        .irq_ack  (irq_ack),
        .irq_ret  (irq_ret)
    );

    p_slot0_wins_r5: assert property (@(posedge clk) disable iff (rst)
        issue && !busy && br_valid[0] && (br_guard[0] == br_sense[0]) |=>
            busy && tgt == $past(br_target[0]));

    p_invalid_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        !instr_valid && !busy |=> !busy);

endmodule

// File: tb/brctl_unit_tb_top.sv
module brctl_unit_tb_top;

    localparam int unsigned NBR      = 3;
    localparam int unsigned DELAY    = 3;
    localparam logic [31:0] RESET_PC = 32'h0000_1000;

    logic clk = 1'b0;
    logic rst;
    logic instr_valid, stall, irq_req;
    logic [NBR-1:0] br_valid, br_sense, br_guard;
    logic [NBR-1:0][31:0] br_target;
    logic [31:0] irq_vec;
    logic [31:0] fetch_pc, irq_ret;
    logic redirect, irq_ack;

    always #2.5 clk = ~clk;   // 200 MHz

    brctl_unit #(.NBR(NBR), .DELAY(DELAY), .RESET_PC(RESET_PC)) dut_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .stall(stall),
        .br_valid(br_valid), .br_sense(br_sense), .br_guard(br_guard),
        .br_target(br_target), .irq_req(irq_req), .irq_vec(irq_vec),
        .fetch_pc(fetch_pc), .redirect(redirect), .irq_ack(irq_ack),
        .irq_ret(irq_ret)
    );

    int errors = 0;
    int checks = 0;
    string scen = "";

    // reference state built from the requirements
    logic [31:0] m_pc, m_tgt, m_ret;
    logic m_busy, m_redir, m_ack, m_last_fire;
    int m_left;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%h expected=%h", tag, scen, act, exp);
        end
    endtask

    function automatic logic slot_taken(input int s);
        return br_valid[s] && (br_guard[s] == br_sense[s]);   // R4
    endfunction

    task automatic model_advance();
        logic iss, fire;
        iss  = instr_valid && !stall;
        fire = m_busy && iss && (m_left == 1);
        m_last_fire = fire;
        m_redir = fire;
        m_ack   = fire && irq_req;
        if (fire && irq_req) m_ret = m_tgt;
        if (!stall) m_pc = fire ? (irq_req ? irq_vec : m_tgt) : m_pc + 32'd1;
        if (iss) begin
            if (m_busy) begin
                m_left--;
                if (m_left == 0) m_busy = 1'b0;
            end else begin
                for (int s = NBR - 1; s >= 0; s--) begin
                    if (slot_taken(s)) begin
                        m_busy = 1'b1;
                        m_left = DELAY;
                        m_tgt  = br_target[s];
                    end
                end
            end
        end
    endtask

    task automatic step();
        model_advance();
        @(negedge clk);
        chk(m_last_fire ? "R3" : (stall ? "R7" : "R2"), fetch_pc, m_pc);
        chk("R10", {31'b0, redirect}, {31'b0, m_redir});
        chk("R9", {31'b0, irq_ack}, {31'b0, m_ack});
        chk("R9", irq_ret, m_ret);
    endtask

    task automatic idle_inputs();
        instr_valid = 1'b1; stall = 1'b0; irq_req = 1'b0;
        br_valid = '0; br_sense = '0; br_guard = '0;
    endtask

    task automatic set_br(input int s, input logic sense, input logic guard, input logic [31:0] t);
        br_valid[s] = 1'b1; br_sense[s] = sense; br_guard[s] = guard; br_target[s] = t;
    endtask

    task automatic plain(input int n);
        for (int i = 0; i < n; i++) begin
            idle_inputs();
            step();
        end
    endtask

    bit done = 0;

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd20240607);
        idle_inputs();
        instr_valid = 1'b0;
        br_target = '0; irq_vec = 32'h0000_0F00;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        scen = "R1 reset";
        chk("R1", fetch_pc, RESET_PC);
        chk("R1", {30'b0, redirect, irq_ack}, 32'd0);
        chk("R1", irq_ret, 32'd0);
        rst = 1'b0;
        m_pc = RESET_PC; m_tgt = '0; m_ret = '0;
        m_busy = 0; m_redir = 0; m_ack = 0; m_left = 0; m_last_fire = 0;

        scen = "R2 sequential";
        plain(4);

        scen = "R3 R4 jump-if-true";
        idle_inputs(); set_br(0, 1'b1, 1'b1, 32'h0000_2000); step();
        plain(5);

        scen = "R4 jump-if-false and untaken true";
        idle_inputs();
        set_br(0, 1'b0, 1'b1, 32'h0000_3000);
        set_br(1, 1'b0, 1'b0, 32'h0000_3100);
        step();
        plain(5);

        scen = "R5 priority all taken";
        idle_inputs();
        set_br(0, 1'b1, 1'b1, 32'h0000_4000);
        set_br(1, 1'b1, 1'b1, 32'h0000_4100);
        set_br(2, 1'b0, 1'b0, 32'h0000_4200);
        step();
        plain(4);

        scen = "R5 priority upper slots";
        idle_inputs();
        set_br(1, 1'b0, 1'b0, 32'h0000_4500);
        set_br(2, 1'b1, 1'b1, 32'h0000_4600);
        step();
        plain(4);

        scen = "R6 branches in delay slots ignored";
        idle_inputs(); set_br(2, 1'b1, 1'b1, 32'h0000_5000); step();
        for (int i = 0; i < 3; i++) begin
            idle_inputs(); set_br(0, 1'b1, 1'b1, 32'h0000_5A00 + i); step();
        end
        plain(4);

        scen = "R7 stall during window";
        idle_inputs(); set_br(0, 1'b1, 1'b1, 32'h0000_6000); step();
        idle_inputs(); step();
        idle_inputs(); stall = 1'b1; set_br(1, 1'b1, 1'b1, 32'h0000_6600); step();
        idle_inputs(); stall = 1'b1; step();
        plain(4);

        scen = "R8 invalid cycles";
        idle_inputs(); instr_valid = 1'b0; set_br(0, 1'b1, 1'b1, 32'h0000_7700); step();
        plain(4);
        idle_inputs(); set_br(0, 1'b0, 1'b0, 32'h0000_7000); step();
        idle_inputs(); instr_valid = 1'b0; step();
        idle_inputs(); instr_valid = 1'b0; step();
        plain(4);

        scen = "R9 interrupt waits for branch";
        for (int i = 0; i < 5; i++) begin
            idle_inputs(); irq_req = 1'b1; irq_vec = 32'h0000_0F00; step();
        end
        idle_inputs(); irq_req = 1'b1; set_br(1, 1'b1, 1'b1, 32'h0000_8000); step();
        for (int i = 0; i < 3; i++) begin
            idle_inputs(); irq_req = 1'b1; step();
        end
        plain(3);

        scen = "R3 R6 R7 R8 R9 R10 random";
        for (int n = 0; n < 4000; n++) begin
            instr_valid = ($urandom % 10) < 8;
            stall       = ($urandom % 100) < 15;
            irq_req     = ($urandom % 10) == 0;
            irq_vec     = 32'h0000_0F00 + ($urandom % 16);
            for (int s = 0; s < NBR; s++) begin
                br_valid[s]  = ($urandom % 5) == 0;
                br_sense[s]  = $urandom % 2;
                br_guard[s]  = $urandom % 2;
                br_target[s] = $urandom;
            end
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule